// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Trigger

This block raises fill-level interrupt requests for a UART that owns one receive FIFO and one transmit FIFO, each sixteen entries deep by default. It watches the fill count of each FIFO. It compares that count against a threshold picked by a 3-bit select field, and there is a separate field for each direction. For each direction it reports a raw request and an enable-gated request. The FIFO storage and the serial engines sit outside the block. They hand over only their current fill counts.

The receive side asks for service once enough entries have collected. The transmit side asks for service once enough entries have drained. Both sides use the same threshold scale: one eighth, one quarter, one half, three quarters and seven eighths of the depth. With the default depth this gives 2, 4, 8, 12 and 14 entries.

There is no data stream through the block, so it has no valid/ready handshake. Every pin is a plain control or status level. All four outputs are registered and follow their inputs one clock later.

Top module: `fifo_lvl_irq`

## Requirements
- R1: Receive raw request is 1 when the receive fill count is at or above the threshold of the receive select field. Select 0 gives 2 entries, 1 gives 4, 2 gives 8, 3 gives 12 and 4 gives 14 (depth 16).
- R2: Select codes 5, 6 and 7 give the same threshold as code 4 (14 entries), on both directions.
- R3: Transmit raw request is 1 when the transmit fill count is at or below 16 minus the threshold of the transmit select field. The transmit field uses the same encoding as R1 and is independent of the receive field.
- R4: Each enable-gated request equals that direction's raw request ANDed with that direction's enable bit. One direction's enable has no effect on the other direction.
- R5: The requests are level-sensitive. They drop as soon as the fill condition no longer holds, and nothing needs to clear them.
- R6: Every output reflects the inputs that were sampled at the previous rising clock edge, so the latency is exactly one cycle.
- R7: While the active-low reset is asserted, all four outputs are 0.
- R8: A fill count above the depth is treated as full. The receive raw request is then 1 for every select code, and the transmit raw request is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level_i | input | CNT_W (5) | Receive FIFO fill count |
| tx_level_i | input | CNT_W (5) | Transmit FIFO fill count |
| rx_sel_i | input | 3 | Receive threshold select code |
| tx_sel_i | input | 3 | Transmit threshold select code |
| rx_ien_i | input | 1 | Receive request enable |
| tx_ien_i | input | 1 | Transmit request enable |
| rx_raw_o | output | 1 | Receive raw level request |
| rx_irq_o | output | 1 | Receive enable-gated request |
| tx_raw_o | output | 1 | Transmit raw level request |
| tx_irq_o | output | 1 | Transmit enable-gated request |

## Verification
The block holds no state other than its four output registers. A wrong threshold decode therefore appears at the raw output within one cycle of the fill count crossing the boundary it got wrong. Because of this, the bench walks every select code over every fill count on both sides, and it samples exactly one cycle after each change. A gating fault, or leakage between the two directions, appears as a request that disagrees with its own enable or with the other side's field on that same cycle. Stale or sticky state appears as a request that stays high one cycle after its condition goes away.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;

  localparam int SEL_W = 3;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } lvl_dir_e;

  // Threshold in entries for a select code; codes past the top step saturate.
  function automatic int unsigned lvl_thresh(input logic [SEL_W-1:0] code,
                                             input int unsigned depth);
    case (code)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (3 * depth) / 4;
      default: return (7 * depth) / 8;
    endcase
  endfunction

endpackage

// File: rtl/fifo_lvl_decode.sv
module fifo_lvl_decode
  import fifo_lvl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] thr_o
);

  always_comb begin
    thr_o = CNT_W'(lvl_thresh(sel_i, DEPTH));
  end

endmodule

// File: rtl/fifo_lvl_cmp.sv
module fifo_lvl_cmp
  import fifo_lvl_pkg::*;
#(
  parameter int       DEPTH = 16,
  parameter lvl_dir_e DIR   = DIR_RX,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ien_i,
  output logic             raw_o,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] MIN_THR = CNT_W'(DEPTH / 8);
  localparam logic [CNT_W-1:0] MAX_THR = CNT_W'((7 * DEPTH) / 8);

  logic [CNT_W-1:0] thr;
  logic             hit;

  fifo_lvl_decode #(.DEPTH(DEPTH)) u_decode (
    .sel_i (sel_i),
    .thr_o (thr)
  );

  generate
    if (DIR == DIR_RX) begin : g_fill_side
      // Enough entries gathered: at or above the threshold.
      always_comb hit = (level_i >= thr);
    end else begin : g_drain_side
      // Enough room freed: occupied entries at or below depth minus threshold.
      always_comb hit = (level_i <= (DEPTH_C - thr));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      raw_o <= hit;
      irq_o <= hit & ien_i;
    end
  end

  // Becomes 1 one edge after reset release, so that $past sees post-reset inputs.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  generate
    if (DIR == DIR_RX) begin : g_rx_chk
      assert_rx_full_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(level_i) >= DEPTH_C) |-> raw_o);
      assert_rx_below_min_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(level_i) < MIN_THR) |-> !raw_o);
    end else begin : g_tx_chk
      assert_tx_empty_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(level_i) <= (DEPTH_C - MAX_THR)) |-> raw_o);
      assert_tx_above_max_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(level_i) > (DEPTH_C - MIN_THR)) |-> !raw_o);
    end
  endgenerate

  assert_irq_needs_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> raw_o);
  assert_irq_off_when_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(ien_i)) |-> !irq_o);

endmodule

// File: rtl/fifo_lvl_irq.sv
module fifo_lvl_irq
  import fifo_lvl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_level_i,
  input  logic [CNT_W-1:0] tx_level_i,
  input  logic [SEL_W-1:0] rx_sel_i,
  input  logic [SEL_W-1:0] tx_sel_i,
  input  logic             rx_ien_i,
  input  logic             tx_ien_i,
  output logic             rx_raw_o,
  output logic             rx_irq_o,
  output logic             tx_raw_o,
  output logic             tx_irq_o
);

  fifo_lvl_cmp #(.DEPTH(DEPTH), .DIR(DIR_RX)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (rx_level_i),
    .sel_i   (rx_sel_i),
    .ien_i   (rx_ien_i),
    .raw_o   (rx_raw_o),
    .irq_o   (rx_irq_o)
  );

  fifo_lvl_cmp #(.DEPTH(DEPTH), .DIR(DIR_TX)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (tx_level_i),
    .sel_i   (tx_sel_i),
    .ien_i   (tx_ien_i),
    .raw_o   (tx_raw_o),
    .irq_o   (tx_irq_o)
  );

  // Outputs are reset to 0 and held there while reset is asserted.
  always @(posedge clk) begin
    if (!rst_n) assert_quiet_in_reset_R7: assert (!rx_raw_o && !rx_irq_o && !tx_raw_o && !tx_irq_o);
  end

endmodule

// File: tb/fifo_lvl_irq_bench.sv
module fifo_lvl_irq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] rx_level = '0;
  logic [CNT_W-1:0] tx_level = '0;
  logic [2:0]       rx_sel = '0;
  logic [2:0]       tx_sel = '0;
  logic             rx_ien = 1'b0;
  logic             tx_ien = 1'b0;
  logic             rx_raw, rx_irq, tx_raw, tx_irq;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_lvl_irq #(.DEPTH(DEPTH)) u_fifo_lvl_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_level_i (rx_level),
    .tx_level_i (tx_level),
    .rx_sel_i   (rx_sel),
    .tx_sel_i   (tx_sel),
    .rx_ien_i   (rx_ien),
    .tx_ien_i   (tx_ien),
    .rx_raw_o   (rx_raw),
    .rx_irq_o   (rx_irq),
    .tx_raw_o   (tx_raw),
    .tx_irq_o   (tx_irq)
  );

  function automatic int thr_of(input logic [2:0] code);
    case (code)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      default: return 14;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (rxl=%0d rxs=%0d txl=%0d txs=%0d)",
               req, act, exp, rx_level, rx_sel, tx_level, tx_sel);
    end
  endtask

  // Drive at a falling edge, let one rising edge register, sample at the next falling edge.
  task automatic apply(input int rl, input int rs, input int tl, input int ts,
                       input logic re, input logic te);
    @(negedge clk);
    rx_level = CNT_W'(rl); rx_sel = 3'(rs);
    tx_level = CNT_W'(tl); tx_sel = 3'(ts);
    rx_ien = re; tx_ien = te;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rx_level = 5'd16; rx_ien = 1'b1; tx_ien = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 rx_raw", rx_raw, 1'b0);
    check("R7 rx_irq", rx_irq, 1'b0);
    check("R7 tx_raw", tx_raw, 1'b0);
    check("R7 tx_irq", tx_irq, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_rx_sweep;
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c <= DEPTH; c++) begin
        apply(c, s, 8, 0, 1'b1, 1'b0);
        check(s < 5 ? "R1 rx_raw" : "R2 rx_raw", rx_raw, c >= thr_of(3'(s)));
      end
    end
  endtask

  task automatic t_tx_sweep;
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c <= DEPTH; c++) begin
        apply(0, 0, c, s, 1'b0, 1'b1);
        check(s < 5 ? "R3 tx_raw" : "R2 tx_raw", tx_raw, c <= DEPTH - thr_of(3'(s)));
      end
    end
  endtask

  task automatic t_independent_fields;
    // rx at 14 entries with code 4 fires; tx at 14 with code 0 fires too, code 4 would not.
    apply(14, 4, 14, 0, 1'b1, 1'b1);
    check("R3 tx own field", tx_raw, 1'b1);
    check("R1 rx own field", rx_raw, 1'b1);
    apply(3, 0, 3, 4, 1'b1, 1'b1);
    check("R3 tx own field", tx_raw, 1'b0);
    check("R1 rx own field", rx_raw, 1'b1);
  endtask

  task automatic t_mask;
    for (int m = 0; m < 4; m++) begin
      apply(16, 0, 0, 0, m[0], m[1]);
      check("R4 rx_raw ungated", rx_raw, 1'b1);
      check("R4 rx_irq", rx_irq, m[0]);
      check("R4 tx_raw ungated", tx_raw, 1'b1);
      check("R4 tx_irq", tx_irq, m[1]);
    end
    apply(0, 0, 16, 0, 1'b1, 1'b1);
    check("R4 rx_irq no cond", rx_irq, 1'b0);
    check("R4 tx_irq no cond", tx_irq, 1'b0);
  endtask

  task automatic t_level;
    apply(8, 2, 8, 2, 1'b1, 1'b1);
    check("R5 rx up", rx_irq, 1'b1);
    check("R5 tx up", tx_irq, 1'b1);
    apply(7, 2, 9, 2, 1'b1, 1'b1);
    check("R5 rx drops", rx_irq, 1'b0);
    check("R5 tx drops", tx_irq, 1'b0);
    apply(8, 2, 8, 2, 1'b1, 1'b1);
    check("R5 rx again", rx_irq, 1'b1);
    check("R5 tx again", tx_irq, 1'b1);
  endtask

  task automatic t_latency;
    apply(0, 0, 16, 0, 1'b1, 1'b1);
    @(negedge clk);
    rx_level = 5'd16; tx_level = 5'd0;
    @(posedge clk); #1;
    check("R6 rx not early", rx_raw, 1'b1);
    check("R6 tx not early", tx_raw, 1'b1);
    @(negedge clk);
    rx_level = 5'd0; tx_level = 5'd16;
    #1;
    check("R6 rx held", rx_raw, 1'b1);
    check("R6 tx held", tx_raw, 1'b1);
    @(posedge clk); #1;
    check("R6 rx follows", rx_raw, 1'b0);
    check("R6 tx follows", tx_raw, 1'b0);
  endtask

  task automatic t_overrange;
    for (int c = DEPTH + 1; c < 32; c += 5) begin
      for (int s = 0; s < 8; s++) begin
        apply(c, s, c, s, 1'b1, 1'b1);
        check("R8 rx_raw", rx_raw, 1'b1);
        check("R8 tx_raw", tx_raw, 1'b0);
      end
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_rx_sweep();
    t_tx_sweep();
    t_independent_fields();
    t_mask();
    t_level();
    t_latency();
    t_overrange();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

endmodule